// File: doc/BRIEF.md
# Zero-Crossing Interval Commutation Timer

This block times the gap between successive back-EMF zero-crossing pulses of a three-phase motor and uses that gap to schedule the next commutation. An 8-bit interval counter advances once for every prescaled tick. When a zero-crossing strobe arrives, the counter value is captured as the newest interval. The interval captured before it is kept as a history value. The counter then restarts from zero.

The captured interval is scaled by an 8-bit weight to give the commutation delay. The 16-bit product of weight and interval is formed, and its upper byte is the delay, so the delay equals weight × interval / 256. Once the running count after a zero-crossing reaches that delay, the block emits a single commutation strobe. The counter stops at all ones instead of wrapping, and it flags that condition, so a stalled rotor is never mistaken for a fast one.

A drive sequencer around the block feeds it the detected zero-crossing pulses and a tick from a prescaler. It uses the commutation strobe to advance the phase pattern and the overflow flag to detect a stall.

Top module: `zc_commutation_timer`

## Requirements
- R1: While `rst_n` is low, every output is zero, and no commutation strobe can fire until the first zero-crossing after reset.
- R2: On a cycle with `zc_strobe` high, `interval_cur` takes the value the counter held before that edge, and the counter restarts at 0 whatever `tick_en` is.
- R3: On the same edge, `interval_prev` takes the value `interval_cur` held before that edge.
- R4: `comm_delay` always equals bits [15:8] of the 16-bit product `weight * interval_cur`.
- R5: `comm_strobe` is high for exactly one cycle, following the first clock edge at which the strobe is armed, `zc_strobe` is low and the running count is at least `comm_delay`. With a tick every cycle and a delay d, the strobe is high in the cycle after edge d+1 counted from the zero-crossing edge.
- R6: At most one commutation strobe fires per zero-crossing interval, and the next zero-crossing re-arms it.
- R7: The counter saturates at 255 (FFh) and never wraps. `timer_full` is high exactly while the count is 255, and a zero-crossing taken in that state captures 255.
- R8: When `tick_en` is low and no zero-crossing occurs, the count holds its value.
- R9: A zero-crossing that arrives before a pending strobe has fired cancels the pending strobe. The next strobe is then timed from the new interval and the restarted count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaled tick; the counter advances on cycles where it is high |
| zc_strobe | input | 1 | Single-cycle zero-crossing event |
| weight | input | 8 | Delay weight; delay = weight × interval / 256 |
| interval_cur | output | 8 | Most recent captured interval |
| interval_prev | output | 8 | Interval captured before the most recent one |
| comm_delay | output | 8 | Computed commutation delay in ticks |
| comm_strobe | output | 1 | One-cycle commutation event |
| timer_full | output | 1 | Counter is saturated at all ones |

## Verification
The hardest state to reach from the ports is a saturated counter that receives a zero-crossing while a commutation is still pending against a large delay. Reaching it takes more than 255 ticks with no zero-crossing and a weight near full scale. The random phase therefore mixes long quiet stretches, with a very low zero-crossing rate, into bursts of short intervals. A directed sequence then drives the counter to saturation and strikes a zero-crossing just before the strobe is due. Every output is compared, cycle by cycle, against a model kept in the bench.

// File: rtl/zc_commutation_timer.sv
module zc_commutation_timer #(
  parameter int CNT_W = 8,
  parameter int WGT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             zc_strobe,
  input  logic [WGT_W-1:0] weight,
  output logic [CNT_W-1:0] interval_cur,
  output logic [CNT_W-1:0] interval_prev,
  output logic [CNT_W-1:0] comm_delay,
  output logic             comm_strobe,
  output logic             timer_full
);
  localparam int PROD_W = CNT_W + WGT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  count;
  logic              armed;
  logic [PROD_W-1:0] product;
  logic              fire;

  assign product    = PROD_W'(weight) * PROD_W'(interval_cur);
  assign comm_delay = product[PROD_W-1:WGT_W];
  assign timer_full = (count == CNT_MAX);
  assign fire       = armed && !zc_strobe && (count >= comm_delay);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count         <= '0;
      interval_cur  <= '0;
      interval_prev <= '0;
      armed         <= 1'b0;
      comm_strobe   <= 1'b0;
    end else begin
      comm_strobe <= fire;
      if (zc_strobe) begin
        interval_prev <= interval_cur;
        interval_cur  <= count;
        count         <= '0;
        armed         <= 1'b1;
      end else begin
        if (tick_en && !timer_full) count <= count + 1'b1;
        if (fire) armed <= 1'b0;
      end
    end
  end
endmodule

module zc_commutation_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             zc_strobe,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] interval_cur,
  input logic [CNT_W-1:0] interval_prev,
  input logic [CNT_W-1:0] comm_delay,
  input logic             comm_strobe,
  input logic             timer_full
);
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    zc_strobe |=> (interval_cur == $past(count)) && (count == '0));
  assert_history_R3: assert property (@(posedge clk) disable iff (!rst_n)
    zc_strobe |=> interval_prev == $past(interval_cur));
  assert_reach_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(comm_strobe) |-> $past(count) >= $past(comm_delay));
  assert_one_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    comm_strobe |=> !comm_strobe);
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_full && !zc_strobe) |=> timer_full);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !zc_strobe) |=> $stable(count));
endmodule

bind zc_commutation_timer zc_commutation_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .zc_strobe(zc_strobe),
  .count(count), .interval_cur(interval_cur), .interval_prev(interval_prev),
  .comm_delay(comm_delay), .comm_strobe(comm_strobe), .timer_full(timer_full)
);

// File: tb/test_zc_commutation_timer.sv
`timescale 1ns/1ps
module test_zc_commutation_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       zc_strobe = 1'b0;
  logic [7:0] weight = 8'd0;
  logic [7:0] interval_cur, interval_prev, comm_delay;
  logic       comm_strobe, timer_full;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_cnt, m_cur, m_prev;
  logic       m_armed, m_strobe;
  int         strobes_in_interval;

  always #2 clk = ~clk;

  zc_commutation_timer i_zc_commutation_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .zc_strobe(zc_strobe),
    .weight(weight), .interval_cur(interval_cur), .interval_prev(interval_prev),
    .comm_delay(comm_delay), .comm_strobe(comm_strobe), .timer_full(timer_full)
  );

  function automatic logic [7:0] exp_delay(input logic [7:0] w, input logic [7:0] iv);
    logic [15:0] p;
    p = 16'(w) * 16'(iv);
    return p[15:8];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_cur = 0; m_prev = 0; m_armed = 0; m_strobe = 0;
    strobes_in_interval = 0;
  endtask

  task automatic compare_all();
    chk("R2 interval_cur", interval_cur, m_cur);
    chk("R3 interval_prev", interval_prev, m_prev);
    chk("R4 comm_delay", comm_delay, exp_delay(weight, m_cur));
    chk("R5 comm_strobe", comm_strobe, m_strobe);
    chk("R7 timer_full", timer_full, m_cnt == 8'd255);
  endtask

  task automatic step(input logic z, input logic t, input logic [7:0] w);
    logic fire;
    zc_strobe = z; tick_en = t; weight = w;
    @(posedge clk);
    fire = m_armed && !z && (m_cnt >= exp_delay(w, m_cur));
    if (z) begin
      m_prev = m_cur; m_cur = m_cnt; m_cnt = 0; m_armed = 1;
      strobes_in_interval = 0;
    end else begin
      if (t && m_cnt != 8'd255) m_cnt = m_cnt + 8'd1;
      if (fire) m_armed = 0;
    end
    m_strobe = fire;
    @(negedge clk);
    compare_all();
    if (comm_strobe) begin
      strobes_in_interval++;
      if (strobes_in_interval > 1)
        chk("R6 strobes per interval", strobes_in_interval, 1);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int s;
    logic [7:0] w;
    logic [7:0] saw;
    int seen;
    s = $urandom(32'd20240611);
    model_reset();
    zc_strobe = 1'b1; tick_en = 1'b1; weight = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 interval_cur", interval_cur, 0);
    chk("R1 interval_prev", interval_prev, 0);
    chk("R1 comm_delay", comm_delay, 0);
    chk("R1 comm_strobe", comm_strobe, 0);
    chk("R1 timer_full", timer_full, 0);
    rst_n = 1'b1;
    // R1: no strobe before first zero-crossing, even with delay 0
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      step(1'b0, 1'b1, 8'd0);
      if (comm_strobe) seen++;
    end
    chk("R1 no strobe before first zc", seen, 0);

    // R2/R3: capture of known intervals
    step(1'b1, 1'b1, 8'd128);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 8'd128);
    step(1'b1, 1'b1, 8'd128);
    chk("R2 captured 40", interval_cur, 40);
    chk("R3 previous 20", interval_prev, 20);

    // R5: strobe timing, delay 20 -> strobe after edge 21
    saw = 0;
    for (int i = 1; i <= 30; i++) begin
      step(1'b0, 1'b1, 8'd128);
      if (comm_strobe && saw == 0) saw = 8'(i);
    end
    chk("R5 strobe edge index", saw, 21);

    // R8: tick gating
    step(1'b1, 1'b1, 8'd0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 8'd0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 8'd0);
    for (int i = 0; i < 7; i++) step(1'b0, 1'b0, 8'd0);
    step(1'b1, 1'b0, 8'd0);
    chk("R8 gated interval", interval_cur, 5);

    // R7: saturation
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 8'd0);
    chk("R7 full after 300 ticks", timer_full, 1);
    step(1'b1, 1'b1, 8'd255);
    chk("R7 captured saturated", interval_cur, 255);
    chk("R4 delay 255x255", comm_delay, 254);

    // R9: zc before pending strobe fires, from saturation, weight full
    for (int i = 0; i < 260; i++) step(1'b0, 1'b1, 8'd255);
    step(1'b1, 1'b1, 8'd255);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      step(1'b0, 1'b1, 8'd255);
      if (comm_strobe) seen++;
    end
    step(1'b1, 1'b1, 8'd64);
    chk("R9 strobe cancelled", seen, 0);
    saw = 0;
    for (int i = 1; i <= 40; i++) begin
      step(1'b0, 1'b1, 8'd64);
      if (comm_strobe && saw == 0) saw = 8'(i);
    end
    chk("R9 retimed strobe edge", saw, 26);

    // R6: one strobe only, long interval with small delay
    step(1'b1, 1'b1, 8'd10);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      step(1'b0, 1'b1, 8'd10);
      if (comm_strobe) seen++;
    end
    chk("R6 single strobe", seen, 1);

    // Random phase
    w = 8'd100;
    for (int blk = 0; blk < 60; blk++) begin
      int zc_rate;
      zc_rate = (blk % 3 == 0) ? 400 : 30;
      for (int i = 0; i < 600; i++) begin
        if ($urandom_range(0, 99) == 0) w = 8'($urandom);
        step($urandom_range(0, zc_rate - 1) == 0,
             $urandom_range(0, 3) != 0, w);
      end
    end

    done = 1;
    finish_run();
  end
endmodule